// File: doc/BRIEF.md
# AXI Burst Beat Lane Generator

This block turns a single AXI address-phase request into a stream of per-beat records. A request gives a start address, a length field, a size field and a burst type. For each data beat the block emits the beat address, the byte-lane strobe mask for a 16-lane (128-bit) data bus, and the lane offset where a narrow transfer's bytes start within the wide word. A narrow master or slave uses these records to place write data or pick read data on the correct lanes.

Two burst kinds are supported. In an incrementing burst the address moves up by the beat size on each beat, so the active lanes walk across the wide word. In a fixed burst every beat reuses the start address, so the same unaligned narrow lane group is driven on every beat. This is the usual pattern for pushing into or draining a FIFO-like target. Requests are taken only while no burst is in progress. Beats leave through a valid/ready handshake, and a last flag marks the final beat. Unsupported sizes and burst encodings are rejected with a one-cycle error pulse and produce no beats.

Top module: `axi_beat_lane_gen`

## Requirements
- R1: `req_ready` is high exactly when no burst is in progress, and `beat_valid` is never high at the same time. A request offered while a burst is in progress has no effect on the beat stream.
- R2: An accepted valid request with length field L produces exactly L+1 beats. `beat_last` is high only on the beat with index L, counting from 0.
- R3: When `req_burst` is 0 (fixed), every beat carries the start address, and the same strobe and lane offset.
- R4: With bytes = 2^size and off = address bits [3:0], the strobe sets lanes off up to (off rounded down to a multiple of bytes) + bytes − 1. For example, size 2 at offset 0x4 gives 0x00F0, and size 1 at offset 0x2 gives 0x000C (lanes 2 and 3).
- R5: When `req_burst` is 1 (incrementing), beat 0 carries the start address unchanged. Beat k > 0 carries (start address with its low size bits cleared) + k·bytes, wrapping modulo 2^ADDR_W.
- R6: `beat_offset` equals the beat address bits [3:0] with the low size bits cleared.
- R7: While `beat_valid` is high and `beat_ready` is low, the beat address, strobe, offset, last flag and valid hold steady.
- R8: A request with size above 4 or a burst type of 2 or 3 is accepted. `req_err` then goes high for the following cycle, no beat is produced, and `req_ready` stays high.
- R9: After reset, `req_ready` is 1, and `beat_valid` and `req_err` are 0.
- R10: The first beat is valid in the cycle after a valid request is accepted. In the cycle after the last beat is taken, `req_ready` is high again and `beat_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | 0 fixed, 1 incrementing, others rejected |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| beat_valid | output | 1 | Beat record valid |
| beat_ready | input | 1 | Beat record taken |
| beat_addr | output | ADDR_W | Beat address |
| beat_strb | output | DATA_BYTES | Byte-lane strobe |
| beat_offset | output | $clog2(DATA_BYTES) | Lane where the narrow group starts |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit length field and 16 byte lanes. At this size a full sweep is possible. It covers both burst kinds, every legal size 0 to 4, every one of the 16 start offsets within the wide word, and lengths 0, 1, 2 and 5. Each beat is compared against an arithmetic model while a pseudo-random ready pattern inserts stalls. Directed runs cover the two narrow fixed-burst lane cases, requests offered while a burst is in progress, and every rejected size or burst encoding.

// File: rtl/axi_blg_pkg.sv
package axi_blg_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_RSV2  = 2'd2,
    BURST_RSV3  = 2'd3
  } burst_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } gen_state_e;
endpackage

// File: rtl/axi_blg_req_check.sv
module axi_blg_req_check #(
  parameter int OFF_W = 4
) (
  input  logic [2:0] size,
  input  logic [1:0] burst,
  output logic       ok
);
  import axi_blg_pkg::*;
  localparam logic [2:0] MAX_SIZE = 3'(OFF_W);

  logic size_ok, burst_ok;

  always_comb begin
    size_ok  = (size <= MAX_SIZE);
    burst_ok = (burst == BURST_FIXED) || (burst == BURST_INCR);
    ok       = size_ok && burst_ok;
  end
endmodule

// File: rtl/axi_blg_addr_step.sv
module axi_blg_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] next_addr
);
  import axi_blg_pkg::*;

  logic [ADDR_W-1:0] sz_mask;
  logic [ADDR_W-1:0] aligned;

  always_comb begin
    sz_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
    aligned = cur_addr & ~sz_mask;
    if (burst == BURST_INCR) next_addr = aligned + sz_mask + ADDR_W'(1);
    else                     next_addr = cur_addr;
  end
endmodule

// File: rtl/axi_blg_lane_mask.sv
module axi_blg_lane_mask #(
  parameter int DATA_BYTES = 16,
  localparam int OFF_W = $clog2(DATA_BYTES)
) (
  input  logic [OFF_W-1:0]      off,
  input  logic [2:0]            size,
  output logic [DATA_BYTES-1:0] strb,
  output logic [OFF_W-1:0]      lane_base
);
  logic [OFF_W:0] lmask;
  logic [OFF_W:0] start_w;
  logic [OFF_W:0] end_excl;

  always_comb begin
    lmask     = ((OFF_W+1)'(1) << size) - (OFF_W+1)'(1);
    start_w   = {1'b0, off};
    lane_base = off & ~lmask[OFF_W-1:0];
    end_excl  = {1'b0, lane_base} + lmask + (OFF_W+1)'(1);
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    localparam logic [OFF_W:0] LANE = (OFF_W+1)'(i);
    assign strb[i] = (LANE >= start_w) && (LANE < end_excl);
  end
endmodule

// File: rtl/axi_beat_lane_gen.sv
module axi_beat_lane_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int DATA_BYTES = 16,
  localparam int OFF_W     = $clog2(DATA_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [2:0]            req_size,
  input  logic [1:0]            req_burst,
  output logic                  req_err,
  output logic                  beat_valid,
  input  logic                  beat_ready,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic [OFF_W-1:0]      beat_offset,
  output logic                  beat_last
);
  import axi_blg_pkg::*;

  gen_state_e            state_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [LEN_W-1:0]      len_q;
  logic [LEN_W-1:0]      cnt_q;
  logic [2:0]            size_q;
  logic [1:0]            burst_q;
  logic [DATA_BYTES-1:0] strb_q;
  logic [OFF_W-1:0]      off_q;
  logic                  last_q;
  logic                  valid_q;
  logic                  err_q;

  logic                  req_ok;
  logic [ADDR_W-1:0]     step_addr;
  logic [ADDR_W-1:0]     load_addr;
  logic [2:0]            load_size;
  logic [DATA_BYTES-1:0] mask_strb;
  logic [OFF_W-1:0]      mask_base;
  logic                  take_req;
  logic                  take_beat;
  logic [LEN_W-1:0]      cnt_inc;

  axi_blg_req_check #(.OFF_W(OFF_W)) u_check (
    .size  (req_size),
    .burst (req_burst),
    .ok    (req_ok)
  );

  axi_blg_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr  (addr_q),
    .size      (size_q),
    .burst     (burst_q),
    .next_addr (step_addr)
  );

  always_comb begin
    load_addr = (state_q == ST_IDLE) ? req_addr : step_addr;
    load_size = (state_q == ST_IDLE) ? req_size : size_q;
    take_req  = req_valid && (state_q == ST_IDLE);
    take_beat = valid_q && beat_ready;
    cnt_inc   = cnt_q + LEN_W'(1);
  end

  axi_blg_lane_mask #(.DATA_BYTES(DATA_BYTES)) u_mask (
    .off       (load_addr[OFF_W-1:0]),
    .size      (load_size),
    .strb      (mask_strb),
    .lane_base (mask_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      strb_q  <= '0;
      off_q   <= '0;
      last_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (take_req) begin
          if (req_ok) begin
            state_q <= ST_BUSY;
            addr_q  <= req_addr;
            len_q   <= req_len;
            cnt_q   <= '0;
            size_q  <= req_size;
            burst_q <= req_burst;
            strb_q  <= mask_strb;
            off_q   <= mask_base;
            last_q  <= (req_len == '0);
            valid_q <= 1'b1;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (take_beat) begin
        if (last_q) begin
          state_q <= ST_IDLE;
          valid_q <= 1'b0;
          last_q  <= 1'b0;
        end else begin
          addr_q <= step_addr;
          cnt_q  <= cnt_inc;
          strb_q <= mask_strb;
          off_q  <= mask_base;
          last_q <= (cnt_inc == len_q);
        end
      end
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign req_err     = err_q;
  assign beat_valid  = valid_q;
  assign beat_addr   = addr_q;
  assign beat_strb   = strb_q;
  assign beat_offset = off_q;
  assign beat_last   = last_q;
endmodule

// File: rtl/axi_beat_lane_gen_sva.sv
module axi_beat_lane_gen_sva #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  localparam int OFF_W     = $clog2(DATA_BYTES)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [2:0]            req_size,
  input logic [1:0]            req_burst,
  input logic                  req_err,
  input logic                  beat_valid,
  input logic                  beat_ready,
  input logic [ADDR_W-1:0]     beat_addr,
  input logic [DATA_BYTES-1:0] beat_strb,
  input logic [OFF_W-1:0]      beat_offset,
  input logic                  beat_last
);
  logic fixed_q;

  always_ff @(posedge clk) begin
    if (rst) fixed_q <= 1'b0;
    else if (req_valid && req_ready) fixed_q <= (req_burst == 2'd0);
  end

  assert_idle_excl_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !beat_valid);

  assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && !beat_last && fixed_q |=>
      beat_valid && $stable(beat_addr) && $stable(beat_strb));

  assert_strb_live_R4: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_strb != '0));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
      $stable(beat_strb) && $stable(beat_offset) && $stable(beat_last));

  assert_err_nobeat_R8: assert property (@(posedge clk) disable iff (rst)
    req_err |-> !beat_valid && req_ready);

  assert_bad_size_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_size > 3'(OFF_W)) |=> req_err && !beat_valid);

  assert_first_beat_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_size <= 3'(OFF_W)) && (req_burst < 2'd2) |=>
      beat_valid && !req_err);

  assert_return_idle_R10: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && beat_last |=> req_ready && !beat_valid);
endmodule

bind axi_beat_lane_gen axi_beat_lane_gen_sva #(
  .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)
) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .req_burst(req_burst), .req_err(req_err),
  .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
  .beat_strb(beat_strb), .beat_offset(beat_offset), .beat_last(beat_last)
);

// File: tb/axi_beat_lane_gen_tb.sv
module axi_beat_lane_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W = 8;
  localparam int DB = 16;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [2:0] req_size = '0;
  logic [1:0] req_burst = '0;
  logic req_err;
  logic beat_valid;
  logic beat_ready = 1'b0;
  logic [ADDR_W-1:0] beat_addr;
  logic [DB-1:0] beat_strb;
  logic [OW-1:0] beat_offset;
  logic beat_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [DB-1:0] seen_or;
  int seen_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_beat_lane_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DB)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
    .req_burst(req_burst), .req_err(req_err), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_strb(beat_strb),
    .beat_offset(beat_offset), .beat_last(beat_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] a,
      input int size, input int burst, input int k);
    logic [ADDR_W-1:0] bytes = ADDR_W'(1) << size;
    if (burst == 0 || k == 0) return a;
    return (a & ~(bytes - 1)) + ADDR_W'(k) * bytes;
  endfunction

  function automatic logic [DB-1:0] exp_strb(input logic [ADDR_W-1:0] a, input int size);
    int off = int'(a[OW-1:0]);
    int bytes = 1 << size;
    int top = (off / bytes) * bytes + bytes;
    logic [DB-1:0] s = '0;
    for (int i = 0; i < DB; i++) if (i >= off && i < top) s[i] = 1'b1;
    return s;
  endfunction

  task automatic run_burst(input logic [ADDR_W-1:0] a, input int len,
                           input int size, input int burst, input bit poke);
    int k = 0;
    bit rdy;
    logic [ADDR_W-1:0] ea;
    logic [OW-1:0] eo;
    seen_or = '0;
    seen_cnt = 0;
    @(negedge clk);
    req_addr = a; req_len = LEN_W'(len); req_size = 3'(size);
    req_burst = 2'(burst); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(beat_valid === 1'b1, "R10 first beat valid", 64'(beat_valid), 1);
    while (k <= len) begin
      ea = exp_addr(a, size, burst, k);
      eo = ea[OW-1:0] & ~OW'((1 << size) - 1);
      chk(beat_valid === 1'b1, "R2 beat valid", 64'(beat_valid), 1);
      chk(beat_addr === ea, burst == 0 ? "R3 fixed addr" : "R5 incr addr",
          64'(beat_addr), 64'(ea));
      chk(beat_strb === exp_strb(ea, size), "R4 strobe", 64'(beat_strb),
          64'(exp_strb(ea, size)));
      chk(beat_offset === eo, "R6 offset", 64'(beat_offset), 64'(eo));
      chk(beat_last === (k == len), "R2 last flag", 64'(beat_last), 64'(k == len));
      chk(req_ready === 1'b0, "R1 busy", 64'(req_ready), 0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = lfsr[0] | lfsr[3];
      beat_ready = rdy;
      if (poke && k < len) begin
        req_valid = 1'b1; req_addr = ~a; req_size = 3'd0; req_burst = 2'd1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      if (rdy) begin
        seen_or |= ea == beat_addr ? beat_strb : '0;
        seen_or |= exp_strb(ea, size);
        seen_cnt++;
        k++;
      end else begin
        chk(beat_addr === ea && beat_last === (k == len), "R7 stall hold",
            64'(beat_addr), 64'(ea));
      end
    end
    beat_ready = 1'b0;
    req_valid = 1'b0;
    chk(req_ready === 1'b1 && beat_valid === 1'b0, "R10 back to idle",
        64'({req_ready, beat_valid}), 64'(2'b10));
  endtask

  task automatic run_bad(input int size, input int burst);
    @(negedge clk);
    req_addr = 32'h6116_0300; req_len = 8'd3; req_size = 3'(size);
    req_burst = 2'(burst); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err === 1'b1, "R8 error pulse", 64'(req_err), 1);
    chk(beat_valid === 1'b0 && req_ready === 1'b1, "R8 no beat",
        64'({beat_valid, req_ready}), 64'(2'b01));
    @(negedge clk);
    chk(req_err === 1'b0 && beat_valid === 1'b0, "R8 pulse ends",
        64'({req_err, beat_valid}), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    int lens[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && beat_valid === 1'b0 && req_err === 1'b0,
        "R9 reset state", 64'({req_ready, beat_valid, req_err}), 64'(3'b100));

    run_burst(32'h6116_0304, 2, 2, 0, 1'b0);
    chk(seen_or === 16'h00F0 && seen_cnt == 3, "R4 fixed 4-byte lanes",
        64'(seen_or), 64'h00F0);
    run_burst(32'h6116_0302, 2, 1, 0, 1'b0);
    chk(seen_or === 16'h000C && seen_cnt == 3, "R4 fixed 2-byte lanes",
        64'(seen_or), 64'h000C);
    run_burst(32'h0000_1005, 4, 2, 1, 1'b1);
    chk(seen_cnt == 5, "R1 busy request ignored", 64'(seen_cnt), 5);
    run_burst(32'hFFFF_FFF8, 3, 2, 1, 1'b0);

    for (int b = 0; b < 2; b++)
      for (int s = 0; s <= 4; s++)
        for (int o = 0; o < 16; o++)
          for (int li = 0; li < 4; li++)
            run_burst(32'h6116_0300 + 32'(o), lens[li], s, b, (o % 5) == 0);

    for (int s = 5; s < 8; s++) run_bad(s, 1);
    run_bad(0, 2);
    run_bad(2, 3);
    run_burst(32'h0000_0040, 0, 4, 1, 1'b0);
    chk(seen_or === 16'hFFFF, "R4 full width", 64'(seen_or), 64'hFFFF);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule